// File: doc/BRIEF.md
# CPU Reset Sequencer

This block is the control state machine of a small bus-based processor, covering only its start-up path. After reset it issues a fixed series of control strobes. The ALU produces zero and the shifter passes that zero through to the shared data bus. An output register captures it and then drives it back onto the bus. The program counter and the address register load the value from the bus. A memory read then runs at address zero. When memory reports ready, the fetched word is loaded into the instruction register and the machine settles in an execute state. Instruction decoding is not part of this block, so the execute state holds with every strobe idle.

The design keeps a clocked state register apart from a purely combinational decoder. The decoder produces the next state and a struct of control strobes, and the top module only joins the two and flattens the strobe struct onto its ports. Reset is asynchronous and active high. The one input that affects the path through the sequence is the memory ready flag.

Top module: `resetSequencer`

## Requirements
- R1: While `rst` is high, the machine is held in its first state at once, without waiting for a clock edge, and the outputs show that state's vector (R2). Once `rst` is low, the state advances on each rising edge of `clk`.
- R2: First state: `aluFunc` = 3'd4 (clear/zero), `shiftMode` = 2'd1 (pass unchanged), and every other output at its idle value. The next state is the second state.
- R3: Second state: same `aluFunc` and `shiftMode` as the first state, plus `outWrEn` = 1. The next state is the third state.
- R4: Third state: `outRdEn` = 1 and all other outputs idle. The next state is the fourth state.
- R5: Fourth state: `outRdEn` = 1, `pcLoadEn` = 1 and `addrLoadEn` = 1, with all other outputs idle. The next state is the fifth state.
- R6: Fifth state: `memRw` = 0 (read) and `memValid` = 1, with all other outputs idle. The next state is the sixth state.
- R7: Sixth state: `memRw` = 0 and `memValid` = 1, and `irLoadEn` follows `memReady` in the same cycle. While `memReady` is 0 the machine stays in this state for any number of cycles. When `memReady` is 1, the next edge moves it to execute.
- R8: Execute state: every output is idle (`aluFunc` = 0, `shiftMode` = 0, all enables 0, `memRw` = 1, `memValid` = 0). The state holds until `rst` is asserted.
- R9: `memReady` has no effect on the outputs or on the state path in any state other than the sixth.
- R10: In every state, at most one source drives the data bus. The three sources are the ALU path (`aluFunc` = 4), the output register (`outRdEn`) and memory (`memValid` with `memRw` = 0).
- R11: Asserting `rst` in the middle of the sequence or in execute returns the machine to the first state, and the sequence then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| memReady | input | 1 | Memory has the read data ready |
| aluFunc | output | 3 | ALU function select (0 idle, 4 zero) |
| shiftMode | output | 2 | Shifter mode (0 idle, 1 pass) |
| outWrEn | output | 1 | Output register write enable |
| outRdEn | output | 1 | Output register drives the bus |
| pcLoadEn | output | 1 | Program counter load from the bus |
| addrLoadEn | output | 1 | Address register load from the bus |
| memRw | output | 1 | Memory direction, 0 = read, 1 = idle/write |
| memValid | output | 1 | Memory address valid |
| irLoadEn | output | 1 | Instruction register load from the bus |

## Verification
The hardest situation to reach is the wait in the sixth state, because its length depends on how long `memReady` stays low. Another hard case is a reset that arrives part way through a stall or part way through the sequence. The stimulus uses directed runs with stall lengths of 0, 1, 3 and 7 cycles, followed by seeded random runs. These random runs choose the stall length, drive `memReady` randomly in every other state, and sometimes drop a reset pulse at a random point in the sequence. A bench model of the state path predicts the full output vector in every cycle.

// File: rtl/resetSequencer_pkg.sv
package resetSequencer_pkg;
  localparam int ALU_W = 3;
  localparam int SHF_W = 2;

  typedef enum logic [2:0] {
    stClrAlu  = 3'd0,
    stCapture = 3'd1,
    stDrive   = 3'd2,
    stLoadPc  = 3'd3,
    stAddrOut = 3'd4,
    stWaitMem = 3'd5,
    stExec    = 3'd6
  } seqState_t;

  typedef struct packed {
    logic [ALU_W-1:0] aluFunc;
    logic [SHF_W-1:0] shiftMode;
    logic             outWrEn;
    logic             outRdEn;
    logic             pcLoadEn;
    logic             addrLoadEn;
    logic             memRw;
    logic             memValid;
    logic             irLoadEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/resetSequencerState.sv
module resetSequencerState
  import resetSequencer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      memReady,
  input  seqState_t nextState,
  output seqState_t curState
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) curState <= stClrAlu;
    else     curState <= nextState;
  end

  // R7: stall while memory is not ready
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (curState == stWaitMem && !memReady) |=> curState == stWaitMem);
  // R7: leave the wait state when ready
  p_go_exec_r7: assert property (@(posedge clk) disable iff (rst)
    (curState == stWaitMem && memReady) |=> curState == stExec);
  // R8: execute holds
  p_exec_hold_r8: assert property (@(posedge clk) disable iff (rst)
    curState == stExec |=> curState == stExec);
  // R2/R3: fixed steps at the start of the sequence
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    curState == stClrAlu |=> curState == stCapture);
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    curState == stCapture |=> curState == stDrive);
endmodule

// File: rtl/resetSequencerDecode.sv
module resetSequencerDecode
  import resetSequencer_pkg::*;
#(
  parameter logic [ALU_W-1:0] ALU_NOP  = 3'd0,
  parameter logic [ALU_W-1:0] ALU_ZERO = 3'd4,
  parameter logic [SHF_W-1:0] SHF_NOP  = 2'd0,
  parameter logic [SHF_W-1:0] SHF_PASS = 2'd1
)(
  input  seqState_t    curState,
  input  logic         memReady,
  output seqState_t    nextState,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes            = '0;
    strobes.aluFunc    = ALU_NOP;
    strobes.shiftMode  = SHF_NOP;
    strobes.memRw      = 1'b1;
    nextState          = curState;
    case (curState)
      stClrAlu: begin
        strobes.aluFunc   = ALU_ZERO;
        strobes.shiftMode = SHF_PASS;
        nextState         = stCapture;
      end
      stCapture: begin
        strobes.aluFunc   = ALU_ZERO;
        strobes.shiftMode = SHF_PASS;
        strobes.outWrEn   = 1'b1;
        nextState         = stDrive;
      end
      stDrive: begin
        strobes.outRdEn = 1'b1;
        nextState       = stLoadPc;
      end
      stLoadPc: begin
        strobes.outRdEn    = 1'b1;
        strobes.pcLoadEn   = 1'b1;
        strobes.addrLoadEn = 1'b1;
        nextState          = stAddrOut;
      end
      stAddrOut: begin
        strobes.memRw    = 1'b0;
        strobes.memValid = 1'b1;
        nextState        = stWaitMem;
      end
      stWaitMem: begin
        strobes.memRw    = 1'b0;
        strobes.memValid = 1'b1;
        if (memReady) begin
          strobes.irLoadEn = 1'b1;
          nextState        = stExec;
        end
      end
      stExec:  nextState = stExec;
      default: nextState = stClrAlu;
    endcase
  end
endmodule

// File: rtl/resetSequencer.sv
module resetSequencer
  import resetSequencer_pkg::*;
#(
  parameter logic [ALU_W-1:0] ALU_NOP  = 3'd0,
  parameter logic [ALU_W-1:0] ALU_ZERO = 3'd4,
  parameter logic [SHF_W-1:0] SHF_NOP  = 2'd0,
  parameter logic [SHF_W-1:0] SHF_PASS = 2'd1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             memReady,
  output logic [ALU_W-1:0] aluFunc,
  output logic [SHF_W-1:0] shiftMode,
  output logic             outWrEn,
  output logic             outRdEn,
  output logic             pcLoadEn,
  output logic             addrLoadEn,
  output logic             memRw,
  output logic             memValid,
  output logic             irLoadEn
);
  seqState_t    curState;
  seqState_t    nextState;
  ctrlStrobes_t strobes;

  resetSequencerState u_state (
    .clk       (clk),
    .rst       (rst),
    .memReady  (memReady),
    .nextState (nextState),
    .curState  (curState)
  );

  resetSequencerDecode #(
    .ALU_NOP  (ALU_NOP),
    .ALU_ZERO (ALU_ZERO),
    .SHF_NOP  (SHF_NOP),
    .SHF_PASS (SHF_PASS)
  ) u_decode (
    .curState  (curState),
    .memReady  (memReady),
    .nextState (nextState),
    .strobes   (strobes)
  );

  assign aluFunc    = strobes.aluFunc;
  assign shiftMode  = strobes.shiftMode;
  assign outWrEn    = strobes.outWrEn;
  assign outRdEn    = strobes.outRdEn;
  assign pcLoadEn   = strobes.pcLoadEn;
  assign addrLoadEn = strobes.addrLoadEn;
  assign memRw      = strobes.memRw;
  assign memValid   = strobes.memValid;
  assign irLoadEn   = strobes.irLoadEn;

  // R10: never two bus drivers at once
  p_one_driver_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({aluFunc == ALU_ZERO, outRdEn, memValid && !memRw}));
  // R8: execute is fully idle
  p_exec_idle_r8: assert property (@(posedge clk) disable iff (rst)
    curState == stExec |-> (!memValid && memRw && !outWrEn && !outRdEn &&
                            !pcLoadEn && !addrLoadEn && !irLoadEn));
  // R7: instruction load only with ready during the memory wait
  p_ir_load_r7: assert property (@(posedge clk) disable iff (rst)
    irLoadEn |-> (memReady && memValid && !memRw));
  // R5: pc and address register load together
  p_load_pair_r5: assert property (@(posedge clk) disable iff (rst)
    pcLoadEn |-> (addrLoadEn && outRdEn));
endmodule

// File: tb/resetSequencer_bench.sv
module resetSequencer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic memReady = 1'b0;
  logic [2:0] aluFunc;
  logic [1:0] shiftMode;
  logic outWrEn, outRdEn, pcLoadEn, addrLoadEn, memRw, memValid, irLoadEn;

  int testsRun = 0;
  int testsFailed = 0;
  int expState = 1;   // 1..6 sequence steps, 7 = execute
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resetSequencer u_resetSequencer (
    .clk(clk), .rst(rst), .memReady(memReady),
    .aluFunc(aluFunc), .shiftMode(shiftMode), .outWrEn(outWrEn),
    .outRdEn(outRdEn), .pcLoadEn(pcLoadEn), .addrLoadEn(addrLoadEn),
    .memRw(memRw), .memValid(memValid), .irLoadEn(irLoadEn)
  );

  // Spec model of the state path
  always @(posedge clk or posedge rst) begin
    if (rst) expState <= 1;
    else if (expState >= 1 && expState <= 5) expState <= expState + 1;
    else if (expState == 6) expState <= memReady ? 7 : 6;
  end

  // {aluFunc, shiftMode, outWrEn, outRdEn, pcLoadEn, addrLoadEn, memRw, memValid, irLoadEn}
  function automatic logic [11:0] expVec(int st, logic rdy);
    case (st)
      1: return {3'd4, 2'd1, 7'b0000100};
      2: return {3'd4, 2'd1, 7'b1000100};
      3: return {3'd0, 2'd0, 7'b0100100};
      4: return {3'd0, 2'd0, 7'b0111100};
      5: return {3'd0, 2'd0, 7'b0000010};
      6: return {3'd0, 2'd0, 6'b000001, rdy};
      default: return {3'd0, 2'd0, 7'b0000100};
    endcase
  endfunction

  function automatic string reqOf(int st);
    case (st)
      1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [11:0] dutVec();
    return {aluFunc, shiftMode, outWrEn, outRdEn, pcLoadEn, addrLoadEn,
            memRw, memValid, irLoadEn};
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s state=%0d actual=%h expected=%h", req, expState, act, exp);
    end
  endtask

  task automatic cycle(logic rstVal, logic rdyVal, string tag);
    @(negedge clk);
    rst = rstVal;
    memReady = rdyVal;
    #1;
    check(tag == "" ? reqOf(expState) : tag, dutVec(), expVec(expState, memReady));
    if (!rst && expState != 6 && memReady)
      check("R9", dutVec(), expVec(expState, 1'b0));
    testsRun++;
    if ($countones({aluFunc == 3'd4, outRdEn, memValid && !memRw}) > 1) begin
      testsFailed++;
      $display("FAIL R10 drivers actual=%b expected=at most one",
               {aluFunc == 3'd4, outRdEn, memValid && !memRw});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5EC0_0017);
    #1;
    check("R1", dutVec(), expVec(1, 1'b0));       // async reset at time 0
    for (int run = 0; run < 300; run++) begin
      int stall;
      int execLen;
      int abortAt;
      int step;
      case (run)
        0: stall = 0; 1: stall = 1; 2: stall = 3; 3: stall = 7;
        default: stall = int'($urandom % 10);
      endcase
      execLen = 2 + int'($urandom % 5);
      abortAt = (run >= 4 && ($urandom % 4 == 0)) ? 1 + int'($urandom % 8) : -1;
      cycle(1'b1, 1'($urandom), "R1");
      cycle(1'b1, 1'($urandom), "R1");
      step = 0;
      while (expState != 7) begin
        logic rdy;
        step++;
        if (step == abortAt) begin
          cycle(1'b1, 1'($urandom), "R11");
          abortAt = -1;
          continue;
        end
        if (expState == 6) begin
          rdy = (stall == 0);
          if (stall > 0) stall--;
        end else rdy = 1'($urandom);
        cycle(1'b0, rdy, "");
      end
      for (int e = 0; e < execLen; e++) cycle(1'b0, 1'($urandom), "R8");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule